// File: doc/BRIEF.md
# Reference Pre-Divider and Output Divider Router

This block holds the digital routing and division logic that surrounds a two-stage clock multiplier. The two loops are not part of it. Each clock that enters or leaves the block is carried as a one-cycle event pulse on a common fabric clock, with one pulse per edge of the clock it stands for. The block selects one of two reference event streams and passes it through a pre-divider. The divided stream goes to the first loop's phase comparator. A fixed divide-by-32 on the first loop's oscillator events produces the comparator's feedback stream.

A 3-bit pre-divider code sets a power-of-two ratio from 1 to 32, or it selects one of two bypass routes. In the first bypass route the selected reference feeds the second loop directly, in place of the first loop's oscillator. In the second bypass route the selected reference goes straight to the output dividers, in place of the second loop's high-speed output.

Each output channel divides the high-speed stream and produces a 50% duty level clock. A 2-bit code per channel selects divide by 32, 8 or 4, or a parked state in which the output-enable is low. Any change of a code restarts the affected counter, so the new ratio begins from a clean phase.

Top module: `refdiv_router`

## Requirements
- R1: `ref_sel` low selects `ref0_ev` and `ref_sel` high selects `ref1_ev` as the reference stream for the pre-divider and for both bypass routes.
- R2: For `rdiv_sel` codes 000 to 101 the ratio is 2^code (1, 2, 4, 8, 16, 32). `pd_ref_ev` pulses for one cycle, one clock after the event that completes every ratio-th selected reference event counted since the last configuration change.
- R3: While `rdiv_sel` is 110 or 111, `pd_ref_ev` is low from the next clock edge onward.
- R4: While `rdiv_sel` is 110, `stage2_ref_ev` equals the selected reference event in the same cycle, as combinational routing. For every other code it equals `vcxo_ev`.
- R5: While `rdiv_sel` is 111, every output channel counts selected reference events in place of `mult_ev`.
- R6: Channel code 00 parks the channel: `out_oe` is low, `out_clk` is low and its counter is held at zero. Code 01 divides by 32, code 10 divides by 8 and code 11 divides by 4. Any non-00 code sets `out_oe` high at the next edge.
- R7: A dividing channel starts low and toggles one clock after every N/2-th source event, which gives a 50% duty cycle in source events. Channel i is controlled by `out_sel[2i+1:2i]` alone.
- R8: `pd_fb_ev` pulses for one cycle, one clock after every 32nd `vcxo_ev` counted since reset.
- R9: A change of {`ref_sel`, `rdiv_sel`} clears the pre-divider count and suppresses its pulse in that cycle. A change of a channel's code, or of whether code 111 is in force, clears that channel's count and drives its clock low at the next edge. The source event in that cycle is ignored.
- R10: While `rst_n` is low, all registered outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock on which all event streams are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_ev | input | 1 | Edge events of reference 0 |
| ref1_ev | input | 1 | Edge events of reference 1 |
| ref_sel | input | 1 | Reference select, 0 = ref0, 1 = ref1 |
| rdiv_sel | input | 3 | Pre-divider ratio or bypass code |
| vcxo_ev | input | 1 | Edge events of the first loop's oscillator |
| mult_ev | input | 1 | Edge events of the second loop's high-speed output |
| out_sel | input | 2*NUM_OUT | Per-channel 2-bit output codes |
| pd_ref_ev | output | 1 | Divided reference to the phase comparator |
| pd_fb_ev | output | 1 | Oscillator events divided by 32 |
| stage2_ref_ev | output | 1 | Reference stream for the second loop |
| out_clk | output | NUM_OUT | Divided output clocks |
| out_oe | output | NUM_OUT | Output enables, low when parked |

## Verification
The hardest situations to reach are code changes that arrive in the same cycle as a source event, and changes of the routing mode (code 111 on or off) while a channel keeps its own code. Only these paths exercise the restart rules. The stimulus steps through every pre-divider code against every channel code, in an order where each step changes the configuration while random-density events keep arriving. It also inserts short runs of a few cycles between steps, so that restarts fall mid-period. A behavioural model in the bench counts events since the last restart and is compared with every output on every clock.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int unsigned RDIV_CW = 5;   // pre-divider count width, ratio up to 32
  localparam int unsigned ODIV_CW = 4;   // output half-period count width, up to 16
  localparam int unsigned FB_CW   = 5;   // feedback divider width, ratio 32

  localparam logic [2:0] RCODE_SKIP1   = 3'b110;
  localparam logic [2:0] RCODE_SKIPALL = 3'b111;
  localparam logic [1:0] OCODE_PARK    = 2'b00;

  // ratio minus one for a power-of-two code: a mask of 'code' ones
  function automatic logic [RDIV_CW-1:0] rdiv_last(input logic [2:0] code);
    logic [RDIV_CW-1:0] m;
    m = '0;
    for (int i = 0; i < RDIV_CW; i++)
      if (i < int'(code)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic rdiv_bypass(input logic [2:0] code);
    return code[2] & code[1];
  endfunction

  // half period minus one, in source events
  function automatic logic [ODIV_CW-1:0] odiv_half_last(input logic [1:0] code);
    case (code)
      2'b01:   return ODIV_CW'(15);
      2'b10:   return ODIV_CW'(3);
      2'b11:   return ODIV_CW'(1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/refdiv_evdiv.sv
module refdiv_evdiv #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          ev,
  input  logic [CW-1:0] last,
  output logic          pulse
);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = ev && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr || hold) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap;
      if (wrap)    cnt <= '0;
      else if (ev) cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold) |-> (cnt <= last));

  p_pulse_ev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(ev));

endmodule

// File: rtl/refdiv_outdiv.sv
module refdiv_outdiv
  import refdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       route_all,
  input  logic       src_ev,
  output logic       q,
  output logic       oe
);

  logic [2:0]         cfg, cfg_q;
  logic               cfg_chg;
  logic               parked;
  logic [ODIV_CW-1:0] cnt;
  logic [ODIV_CW-1:0] half_last;

  assign cfg       = {route_all, sel};
  assign cfg_chg   = (cfg != cfg_q);
  assign parked    = (sel == OCODE_PARK);
  assign half_last = odiv_half_last(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt   <= '0;
      q     <= 1'b0;
      oe    <= 1'b0;
    end else begin
      cfg_q <= cfg;
      oe    <= !parked;
      if (cfg_chg || parked) begin
        cnt <= '0;
        q   <= 1'b0;
      end else if (src_ev) begin
        if (cnt == half_last) begin
          cnt <= '0;
          q   <= ~q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    parked |=> (!oe && !q));

  p_oe_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !parked |=> oe);

  p_edge_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> ($past(src_ev) || $past(cfg_chg)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !q);

endmodule

// File: rtl/refdiv_router.sv
module refdiv_router
  import refdiv_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref0_ev,
  input  logic                   ref1_ev,
  input  logic                   ref_sel,
  input  logic [2:0]             rdiv_sel,
  input  logic                   vcxo_ev,
  input  logic                   mult_ev,
  input  logic [2*NUM_OUT-1:0]   out_sel,
  output logic                   pd_ref_ev,
  output logic                   pd_fb_ev,
  output logic                   stage2_ref_ev,
  output logic [NUM_OUT-1:0]     out_clk,
  output logic [NUM_OUT-1:0]     out_oe
);

  localparam logic [FB_CW-1:0] FB_LAST = '1;

  logic       sel_ev;
  logic       skip1, skip_all, bypass;
  logic [3:0] pcfg, pcfg_q;
  logic       pcfg_chg;
  logic       out_src_ev;

  assign sel_ev   = ref_sel ? ref1_ev : ref0_ev;
  assign skip1    = (rdiv_sel == RCODE_SKIP1);
  assign skip_all = (rdiv_sel == RCODE_SKIPALL);
  assign bypass   = rdiv_bypass(rdiv_sel);
  assign pcfg     = {ref_sel, rdiv_sel};
  assign pcfg_chg = (pcfg != pcfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcfg_q <= '0;
    else        pcfg_q <= pcfg;
  end

  refdiv_evdiv #(.CW(RDIV_CW)) u_prediv (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pcfg_chg),
    .hold  (bypass),
    .ev    (sel_ev),
    .last  (rdiv_last(rdiv_sel)),
    .pulse (pd_ref_ev)
  );

  refdiv_evdiv #(.CW(FB_CW)) u_fbdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .hold  (1'b0),
    .ev    (vcxo_ev),
    .last  (FB_LAST),
    .pulse (pd_fb_ev)
  );

  assign stage2_ref_ev = skip1 ? sel_ev : vcxo_ev;
  assign out_src_ev    = skip_all ? sel_ev : mult_ev;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    refdiv_outdiv u_odiv (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (out_sel[2*g +: 2]),
      .route_all (skip_all),
      .src_ev    (out_src_ev),
      .q         (out_clk[g]),
      .oe        (out_oe[g])
    );
  end

  p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !pd_ref_ev);

  p_fb_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_fb_ev |=> !pd_fb_ev);

  p_prediv_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pcfg_chg |=> !pd_ref_ev);

endmodule

// File: tb/sim_refdiv_router.sv
`timescale 1ns/1ps
module sim_refdiv_router;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref0_ev = 0, ref1_ev = 0, ref_sel = 0, vcxo_ev = 0, mult_ev = 0;
  logic [2:0] rdiv_sel = 0;
  logic [3:0] out_sel = 0;
  logic       pd_ref_ev, pd_fb_ev, stage2_ref_ev;
  logic [1:0] out_clk, out_oe;

  always #10 clk = ~clk;

  refdiv_router #(.NUM_OUT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ref0_ev(ref0_ev), .ref1_ev(ref1_ev),
    .ref_sel(ref_sel), .rdiv_sel(rdiv_sel), .vcxo_ev(vcxo_ev), .mult_ev(mult_ev),
    .out_sel(out_sel), .pd_ref_ev(pd_ref_ev), .pd_fb_ev(pd_fb_ev),
    .stage2_ref_ev(stage2_ref_ev), .out_clk(out_clk), .out_oe(out_oe)
  );

  int n_chk = 0, n_fail = 0;

  // reference model state: events counted since last restart
  logic [3:0] p_prev = 0;
  int         p_tot = 0, f_tot = 0;
  logic [2:0] o_prev [2];
  int         o_tot  [2];
  logic       e_pd = 0, e_fb = 0, e_syn = 0;
  logic       e_q [2];
  logic       e_oe [2];

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_of(input logic [1:0] c);
    return (c == 2'b01) ? 16 : (c == 2'b10) ? 4 : 2;
  endfunction

  // expected outputs after the coming clock edge, from the current inputs
  task automatic model_step();
    logic sev, oev;
    logic [2:0] c;
    logic [1:0] code;
    sev = ref_sel ? ref1_ev : ref0_ev;
    if ({ref_sel, rdiv_sel} != p_prev) begin
      p_tot = 0; e_pd = 0; p_prev = {ref_sel, rdiv_sel};
    end else if (rdiv_sel >= 3'd6) begin
      e_pd = 0;
    end else if (sev) begin
      p_tot++; e_pd = ((p_tot % (1 << rdiv_sel)) == 0);
    end else e_pd = 0;
    if (vcxo_ev) begin
      f_tot++; e_fb = ((f_tot % 32) == 0);
    end else e_fb = 0;
    e_syn = (rdiv_sel == 3'd6) ? sev : vcxo_ev;
    oev = (rdiv_sel == 3'd7) ? sev : mult_ev;
    for (int i = 0; i < 2; i++) begin
      code = out_sel[2*i +: 2];
      c = {rdiv_sel == 3'd7, code};
      e_oe[i] = (code != 2'b00);
      if (c != o_prev[i] || code == 2'b00) begin
        o_tot[i] = 0; e_q[i] = 0;
      end else if (oev) begin
        o_tot[i]++; e_q[i] = ((o_tot[i] / half_of(code)) % 2) == 1;
      end
      o_prev[i] = c;
    end
  endtask

  task automatic compare();
    chk("R2/R3/R1/R9 pd_ref_ev", pd_ref_ev, e_pd);
    chk("R8 pd_fb_ev", pd_fb_ev, e_fb);
    chk("R4 stage2_ref_ev", stage2_ref_ev, e_syn);
    for (int i = 0; i < 2; i++) begin
      chk("R6/R7/R5/R9 out_clk", out_clk[i], e_q[i]);
      chk("R6 out_oe", out_oe[i], e_oe[i]);
    end
  endtask

  task automatic run(input int cycles, input logic rs, input logic [2:0] rd,
                     input logic [3:0] os, input int pr, input int pm);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      compare();
      ref_sel  = rs; rdiv_sel = rd; out_sel = os;
      ref0_ev  = ($urandom_range(99) < pr);
      ref1_ev  = ($urandom_range(99) < pr);
      vcxo_ev  = ($urandom_range(99) < pr);
      mult_ev  = ($urandom_range(99) < pm);
      model_step();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    for (int i = 0; i < 2; i++) begin
      o_prev[i] = 0; o_tot[i] = 0; e_q[i] = 0; e_oe[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 pd_ref_ev", pd_ref_ev, 1'b0);
    chk("R10 pd_fb_ev", pd_fb_ev, 1'b0);
    chk("R10 out_clk0", out_clk[0], 1'b0);
    chk("R10 out_oe1", out_oe[1], 1'b0);
    rst_n = 1'b1;
    model_step();
    // every pre-divider code against every channel code
    for (int rd = 0; rd < 8; rd++)
      for (int oc = 0; oc < 4; oc++) begin
        run(150, rd[0], 3'(rd), {2'(oc), 2'(3 - oc)}, 60, 80);
        run(5, ~rd[0], 3'(rd), {2'(3 - oc), 2'(oc)}, 70, 90);  // R9 mid-period restarts
      end
    // full-rate events, R2 divide by 32 and R8
    run(300, 1'b0, 3'd5, 4'b0111, 100, 100);
    // R1 and R5: reference swap under both-stage bypass
    run(200, 1'b1, 3'd7, 4'b1110, 50, 100);
    run(200, 1'b0, 3'd7, 4'b1110, 50, 100);
    // R4: first-stage bypass with each reference
    run(100, 1'b1, 3'd6, 4'b0101, 50, 100);
    run(100, 1'b0, 3'd6, 4'b0101, 50, 100);
    // R7: one channel parked while the other divides
    run(200, 1'b0, 3'd1, 4'b0010, 40, 100);
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule